// File: doc/BRIEF.md
# Dual-Processor Doorbell Mailbox

This block lets two processors signal each other. Each processor has its own status word of pending doorbell bits. A processor rings the other by writing ones to that target's set alias. The target acknowledges by writing ones to its clear alias. While any pending bit of a target is set, that target's interrupt line stays high.

The block is a 32-bit APB-style slave with a 4 KB address window. It accepts word-aligned, full-word accesses only. A read-only block of twelve identification words sits at the top of the window. The block raises an error flag in two cases: when a register is accessed in the direction it does not support, and when an offset has no register behind it. Both flags are valid during the access phase, alongside the read data.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset both pending words are zero, so `irq0` and `irq1` are low.
- R2: A write to the set alias ORs `pwdata[NBITS-1:0]` into that processor's pending word; higher data bits are ignored. Processor 0's set alias is at offset 0x04 and processor 1's is at 0x14.
- R3: A write to the clear alias clears every pending bit whose data bit is 1 within the low NBITS bits; other bits are unchanged. The clear aliases are at 0x08 (processor 0) and 0x18 (processor 1).
- R4: `irq0` is high exactly when processor 0's pending word is nonzero, and `irq1` likewise for processor 1. The interrupt changes in the cycle after the write's access phase.
- R5: A read of a status offset returns that processor's pending word in bits NBITS-1:0, with all higher bits zero. The status offsets are 0x00 for processor 0 and 0x10 for processor 1.
- R6: A write to a status offset, or to an ID offset, changes no state and asserts `dir_err` during its access phase.
- R7: A read of a set or clear alias returns zero and asserts `dir_err`.
- R8: The twelve words at 0xFD0 to 0xFFC read, in ascending address order, as 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: An access to an offset with no register behind it, or to an address with `paddr[1:0]` not equal to 0, reads zero, ignores write data, and asserts `addr_err` for its access phase.
- R10: A setup phase (`psel` high with `penable` low) has no effect on state or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| dir_err | output | 1 | Wrong-direction access |
| addr_err | output | 1 | Unmapped or misaligned access |
| irq0 | output | 1 | Processor 0 doorbell interrupt |
| irq1 | output | 1 | Processor 1 doorbell interrupt |

## Verification
The hardest behaviour to reach from the ports is that forbidden or malformed writes leave the pending words untouched. This covers writes to a status offset, writes to an ID offset, misaligned writes that fall inside a set alias, and setup phases that never complete. The stimulus first leaves nonzero pending bits in both words, so that an erroneous set or clear would be visible. It then applies each forbidden access and reads both status words back, and checks that both interrupt lines keep their level.

// File: rtl/doorbell_mbox.sv
module doorbell_mbox #(
  parameter int NBITS  = 4,
  parameter int AW     = 12,
  parameter int ID_BASE = 'hFD0,
  parameter int ID_WORDS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          dir_err,
  output logic          addr_err,
  output logic          irq0,
  output logic          irq1
);
  localparam logic [AW-1:0] OFS_STAT0 = AW'('h00);
  localparam logic [AW-1:0] OFS_SET0  = AW'('h04);
  localparam logic [AW-1:0] OFS_CLR0  = AW'('h08);
  localparam logic [AW-1:0] OFS_STAT1 = AW'('h10);
  localparam logic [AW-1:0] OFS_SET1  = AW'('h14);
  localparam logic [AW-1:0] OFS_CLR1  = AW'('h18);
  localparam logic [AW-1:0] ID_LO     = AW'(ID_BASE);
  localparam logic [AW-1:0] ID_HI     = AW'(ID_BASE + 4 * (ID_WORDS - 1));

  logic [NBITS-1:0] pend0, pend1;

  wire acc = psel & penable;
  wire wr  = acc & pwrite;
  wire rd  = acc & ~pwrite;
  wire aligned = (paddr[1:0] == 2'b00);

  wire h_stat0 = aligned && paddr == OFS_STAT0;
  wire h_set0  = aligned && paddr == OFS_SET0;
  wire h_clr0  = aligned && paddr == OFS_CLR0;
  wire h_stat1 = aligned && paddr == OFS_STAT1;
  wire h_set1  = aligned && paddr == OFS_SET1;
  wire h_clr1  = aligned && paddr == OFS_CLR1;
  wire h_id    = aligned && paddr >= ID_LO && paddr <= ID_HI;

  wire h_stat = h_stat0 | h_stat1;
  wire h_wo   = h_set0 | h_clr0 | h_set1 | h_clr1;
  wire known  = h_stat | h_wo | h_id;

  wire [NBITS-1:0] wbits = pwdata[NBITS-1:0];

  function automatic logic [7:0] id_byte(input logic [AW-1:0] idx);
    case (idx)
      0:  id_byte = 8'h04;
      4:  id_byte = 8'h56;
      5:  id_byte = 8'hB8;
      6:  id_byte = 8'h0B;
      8:  id_byte = 8'h0D;
      9:  id_byte = 8'hF0;
      10: id_byte = 8'h05;
      11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  wire [AW-1:0] id_idx = (paddr - ID_LO) >> 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend0 <= '0;
      pend1 <= '0;
    end else if (wr) begin
      if (h_set0) pend0 <= pend0 | wbits;
      if (h_clr0) pend0 <= pend0 & ~wbits;
      if (h_set1) pend1 <= pend1 | wbits;
      if (h_clr1) pend1 <= pend1 & ~wbits;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      if (h_stat0)   prdata = 32'(pend0);
      else if (h_stat1) prdata = 32'(pend1);
      else if (h_id) prdata = 32'(id_byte(id_idx));
    end
  end

  assign dir_err  = (wr & (h_stat | h_id)) | (rd & h_wo);
  assign addr_err = acc & ~known;
  assign irq0 = |pend0;
  assign irq1 = |pend1;

  // R2
  set0_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && h_set0) |=> pend0 == ($past(pend0) | $past(wbits)));
  // R3
  clr1_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && h_clr1) |=> pend1 == ($past(pend1) & ~$past(wbits)));
  // R6
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (h_stat || h_id)) |=> $stable(pend0) && $stable(pend1));
  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> prdata == 32'd0 && !dir_err);
  // R9
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> $stable(pend0) && $stable(pend1));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !penable |=> $stable(pend0) && $stable(pend1));
  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && h_wo) |=> $stable(irq0) && $stable(irq1));
endmodule

// File: tb/doorbell_mbox_tb.sv
module doorbell_mbox_tb;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic dir_err, addr_err, irq0, irq1;
  int vecs = 0, bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_rd;
    logic [31:0] data;
    bit          derr;
    bit          aerr;
    string       req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  doorbell_mbox u_dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .dir_err(dir_err), .addr_err(addr_err), .irq0(irq0), .irq1(irq1));

  // Monitor: compares each access phase with the oldest expected item.
  always @(negedge clk) begin
    if (psel && penable) begin
      exp_t e;
      if (q.size() == 0) begin
        bad++; vecs++;
        $display("FAIL monitor: access with empty scoreboard");
      end else begin
        e = q.pop_front();
        vecs++;
        if ((e.is_rd && prdata !== e.data) || dir_err !== e.derr || addr_err !== e.aerr) begin
          bad++;
          $display("FAIL %s addr=%h: got data=%h derr=%b aerr=%b exp data=%h derr=%b aerr=%b",
                   e.req, paddr, prdata, dir_err, addr_err, e.data, e.derr, e.aerr);
        end
      end
    end
  end

  task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] ed, input bit de, input bit ae, input string r);
    exp_t e;
    e.is_rd = !w; e.data = ed; e.derr = de; e.aerr = ae; e.req = r;
    q.push_back(e);
    @(posedge clk); #1;
    psel = 1; pwrite = w; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string r);
    xfer(1, a, d, 0, 0, 0, r);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] ed, input string r);
    xfer(0, a, 0, ed, 0, 0, r);
  endtask

  task automatic irqs(input bit e0, input bit e1, input string r);
    @(negedge clk);
    vecs++;
    if (irq0 !== e0 || irq1 !== e1) begin
      bad++;
      $display("FAIL %s irq: got %b%b exp %b%b", r, irq0, irq1, e0, e1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    irqs(0, 0, "R1");
    rd(12'h000, 0, "R1");
    rd(12'h010, 0, "R1");
    // R2 R5: upper data bits masked, status reads low bits only
    wr(12'h004, 32'hFFFF_FFF5, "R2");
    rd(12'h000, 32'h5, "R5");
    irqs(1, 0, "R4");
    wr(12'h004, 32'h2, "R2");
    rd(12'h000, 32'h7, "R2");
    // R3
    wr(12'h008, 32'h5, "R3");
    rd(12'h000, 32'h2, "R3");
    wr(12'h008, 32'hFFFF_FFF0, "R3");
    rd(12'h000, 32'h2, "R3");
    wr(12'h014, 32'h8, "R2");
    irqs(1, 1, "R4");
    // R6: writes to read-only offsets
    xfer(1, 12'h010, 32'h0, 0, 1, 0, "R6");
    xfer(1, 12'h000, 32'hF, 0, 1, 0, "R6");
    xfer(1, 12'hFD0, 32'hFF, 0, 1, 0, "R6");
    rd(12'h010, 32'h8, "R6");
    rd(12'h000, 32'h2, "R6");
    rd(12'hFD0, 32'h04, "R6");
    // R7: reads of write-only aliases
    xfer(0, 12'h004, 0, 0, 1, 0, "R7");
    xfer(0, 12'h008, 0, 0, 1, 0, "R7");
    xfer(0, 12'h014, 0, 0, 1, 0, "R7");
    xfer(0, 12'h018, 0, 0, 1, 0, "R7");
    // R8: identification words
    begin
      logic [7:0] ids [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8, 8'h0B, 8'h00,
                               8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 12; i++) rd(12'hFD0 + 12'(4 * i), 32'(ids[i]), "R8");
    end
    // R9: unmapped and misaligned
    xfer(0, 12'h020, 0, 0, 0, 1, "R9");
    xfer(1, 12'h00C, 32'hF, 0, 0, 1, "R9");
    xfer(1, 12'h005, 32'hF, 0, 0, 1, "R9");
    xfer(1, 12'h019, 32'hF, 0, 0, 1, "R9");
    xfer(0, 12'hFCC, 0, 0, 0, 1, "R9");
    xfer(0, 12'h001, 0, 0, 0, 1, "R9");
    rd(12'h000, 32'h2, "R9");
    rd(12'h010, 32'h8, "R9");
    // R10: setup phase that never completes
    @(posedge clk); #1;
    psel = 1; pwrite = 1; paddr = 12'h018; pwdata = 32'hF; penable = 0;
    repeat (3) @(posedge clk); #1;
    psel = 0; pwrite = 0;
    rd(12'h010, 32'h8, "R10");
    irqs(1, 1, "R10");
    // R4: each line follows only its own word
    wr(12'h008, 32'h2, "R3");
    irqs(0, 1, "R4");
    wr(12'h018, 32'hF, "R3");
    irqs(0, 0, "R4");
    rd(12'h010, 0, "R3");
    repeat (2) @(posedge clk);
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: %0d items never observed", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule